// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is one general-purpose I/O port of `W` lines (eight by default) behind a small byte-wide register bus. Software sets, for each line, whether it is driven or read, the level it drives, whether a weak pull resistor is engaged and in which direction, how strong the driver is, and whether the line belongs to the port logic or to an on-chip peripheral. The block turns those settings into per-pad control signals: output value, output enable, pull-up enable, pull-down enable and drive-strength select.

Every pad input passes through a two-flop synchronizer. The synchronized levels can be read back, are passed on to the peripheral, and feed a per-line edge detector. A detected edge on the selected polarity latches a per-line flag. A flag raises the shared interrupt line only if that line's enable bit is set. A single vector register names the lowest-numbered line that is both pending and enabled. Reading the vector acknowledges that line.

Top module: `gpio_port_ctrl`

## Requirements
- R1: The input register (address 0) returns the pin levels two clock edges after they change on `pin_in`. Writes to address 0 have no effect on any register or pad output.
- R2: When a line's function bit (address 5) is 0 and its direction bit (address 2) is 1, `pad_oe` is 1 and `pad_out` equals the output register bit (address 1). When the direction bit is 0, `pad_oe` is 0.
- R3: For a line whose direction bit is 0 and whose pull-enable bit (address 3) is 1, an output register bit of 1 asserts `pad_pull_up` and a 0 asserts `pad_pull_dn`. With pull-enable 0, or with direction 1, neither pull is asserted. The two pulls are never both asserted.
- R4: `pad_drive_full` follows the drive register (address 4): 0 selects reduced drive and 1 selects full drive. After reset every line is at reduced drive.
- R5: When a line's function bit is 1, `pad_out` takes `periph_out` and `pad_oe` is the AND of the direction bit and `periph_oe`. `periph_in` always carries the synchronized pin level.
- R6: A rising edge sets a line's flag (address 8) when its edge bit (address 7) is 0, and a falling edge sets it when the edge bit is 1. This happens whether or not the line's interrupt enable (address 6) is set.
- R7: `irq` is 1 exactly when some line has both its flag and its enable bit set.
- R8: The vector register (address 9) returns 2×(n+1) for the lowest-numbered line n that is flagged and enabled, and returns 0 when no such line exists.
- R9: A read of the vector register clears only the flag of the line it reported. Other flags are unchanged.
- R10: Writing a 1 to a bit of the flag register clears that flag. Writing a 0 leaves it unchanged.
- R11: After reset, the output, direction, pull-enable, drive, function, interrupt-enable, edge and flag registers read 0. All pad enables and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the acknowledge side effect of the vector read) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | W | Asynchronous pad input levels |
| periph_out | input | W | Peripheral output values |
| periph_oe | input | W | Peripheral output enables |
| periph_in | output | W | Synchronized pin levels for the peripheral |
| pad_out | output | W | Value driven on each pad |
| pad_oe | output | W | Pad output enable |
| pad_pull_up | output | W | Pull-up enable |
| pad_pull_dn | output | W | Pull-down enable |
| pad_drive_full | output | W | 1 selects full drive, 0 selects reduced drive |
| irq | output | 1 | Shared interrupt request |

## Verification
Random register settings are combined with random pin and peripheral values. This exercises all combinations of direction, pull-enable, output and function bits, so it can tell apart port mode, peripheral mode, input with a pull, and input with no pull. Random whole-byte pin changes under random edge and enable settings separate rising triggers from falling triggers, and show that a flag latches while its line is masked. Directed cases then cover the following:
- two pending lines, to check the priority order of the vector and its one-line-at-a-time acknowledge;
- the empty vector;
- a write-1-to-clear of the flag register;
- a write to the read-only input register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_IN    = 4'd0,
        A_OUT   = 4'd1,
        A_DIR   = 4'd2,
        A_PEN   = 4'd3,
        A_DRV   = 4'd4,
        A_FSEL  = 4'd5,
        A_IE    = 4'd6,
        A_EDGE  = 4'd7,
        A_FLAG  = 4'd8,
        A_VEC   = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned VEC_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    output logic [DATA_W-1:0] rdata,
    input  logic [W-1:0]      sync_in,
    input  logic [W-1:0]      flag,
    input  logic [VEC_W-1:0]  vec,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      pen_q,
    output logic [W-1:0]      drv_q,
    output logic [W-1:0]      fsel_q,
    output logic [W-1:0]      ie_q,
    output logic [W-1:0]      edge_q,
    output logic [W-1:0]      flag_w1c,
    output logic              vec_rd
);
    function automatic logic [DATA_W-1:0] zext_line(input logic [W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[W-1:0] = v;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] zext_vec(input logic [VEC_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[VEC_W-1:0] = v;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            pen_q  <= '0;
            drv_q  <= '0;
            fsel_q <= '0;
            ie_q   <= '0;
            edge_q <= '0;
        end else if (req.wr) begin
            case (req.addr)
                A_OUT:   out_q  <= req.wdata[W-1:0];
                A_DIR:   dir_q  <= req.wdata[W-1:0];
                A_PEN:   pen_q  <= req.wdata[W-1:0];
                A_DRV:   drv_q  <= req.wdata[W-1:0];
                A_FSEL:  fsel_q <= req.wdata[W-1:0];
                A_IE:    ie_q   <= req.wdata[W-1:0];
                A_EDGE:  edge_q <= req.wdata[W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        flag_w1c = (req.wr && req.addr == A_FLAG) ? req.wdata[W-1:0] : '0;
        vec_rd   = req.rd && (req.addr == A_VEC);
    end

    always_comb begin
        case (req.addr)
            A_IN:    rdata = zext_line(sync_in);
            A_OUT:   rdata = zext_line(out_q);
            A_DIR:   rdata = zext_line(dir_q);
            A_PEN:   rdata = zext_line(pen_q);
            A_DRV:   rdata = zext_line(drv_q);
            A_FSEL:  rdata = zext_line(fsel_q);
            A_IE:    rdata = zext_line(ie_q);
            A_EDGE:  rdata = zext_line(edge_q);
            A_FLAG:  rdata = zext_line(flag);
            A_VEC:   rdata = zext_vec(vec);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     sync_in,
    input  logic [W-1:0]     ie,
    input  logic [W-1:0]     edge_sel,
    input  logic [W-1:0]     flag_w1c,
    input  logic             vec_rd,
    output logic [W-1:0]     flag,
    output logic [VEC_W-1:0] vec,
    output logic             irq
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;
    logic [W-1:0] pending;
    logic [W-1:0] sel_line;
    logic [W-1:0] clr;

    for (genvar i = 0; i < W; i++) begin : g_edge
        always_comb begin
            if (edge_sel_e'(edge_sel[i]) == EDGE_FALL)
                hit[i] = prev_q[i] & ~sync_in[i];
            else
                hit[i] = sync_in[i] & ~prev_q[i];
        end
    end

    assign pending = flag & ie;
    assign irq     = |pending;

    always_comb begin
        vec      = '0;
        sel_line = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pending[i]) begin
                vec      = VEC_W'(2 * (i + 1));
                sel_line = '0;
                sel_line[i] = 1'b1;
            end
        end
    end

    assign clr = flag_w1c | (vec_rd ? sel_line : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag   <= '0;
        end else begin
            prev_q <= sync_in;
            flag   <= (flag & ~clr) | hit;
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pen_q,
    input  logic [W-1:0] drv_q,
    input  logic [W-1:0] fsel_q,
    input  logic [W-1:0] periph_out,
    input  logic [W-1:0] periph_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pull_up,
    output logic [W-1:0] pad_pull_dn,
    output logic [W-1:0] pad_drive_full
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic pull_on;
        assign pull_on = pen_q[i] & ~dir_q[i];

        always_comb begin
            if (fsel_q[i]) begin
                pad_out[i] = periph_out[i];
                pad_oe[i]  = dir_q[i] & periph_oe[i];
            end else begin
                pad_out[i] = out_q[i];
                pad_oe[i]  = dir_q[i];
            end
        end

        assign pad_pull_up[i]    = pull_on &  out_q[i];
        assign pad_pull_dn[i]    = pull_on & ~out_q[i];
        assign pad_drive_full[i] = drv_q[i];
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [W-1:0]      pin_in,
    input  logic [W-1:0]      periph_out,
    input  logic [W-1:0]      periph_oe,
    output logic [W-1:0]      periph_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pull_up,
    output logic [W-1:0]      pad_pull_dn,
    output logic [W-1:0]      pad_drive_full,
    output logic              irq
);
    localparam int unsigned VEC_W = $clog2(2 * W + 1);

    bus_req_t         req;
    logic [W-1:0]     sync_w;
    logic [W-1:0]     flag_w;
    logic [VEC_W-1:0] vec_w;
    logic [W-1:0]     out_w, dir_w, pen_w, drv_w, fsel_w, ie_w, edge_w;
    logic [W-1:0]     w1c_w;
    logic             vec_rd_w;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    gpio_sync #(.W(W)) u_sync (
        .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(sync_w)
    );

    gpio_regs #(.W(W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst(rst), .req(req), .rdata(bus_rdata),
        .sync_in(sync_w), .flag(flag_w), .vec(vec_w),
        .out_q(out_w), .dir_q(dir_w), .pen_q(pen_w), .drv_q(drv_w),
        .fsel_q(fsel_w), .ie_q(ie_w), .edge_q(edge_w),
        .flag_w1c(w1c_w), .vec_rd(vec_rd_w)
    );

    gpio_irq #(.W(W), .VEC_W(VEC_W)) u_irq (
        .clk(clk), .rst(rst), .sync_in(sync_w), .ie(ie_w),
        .edge_sel(edge_w), .flag_w1c(w1c_w), .vec_rd(vec_rd_w),
        .flag(flag_w), .vec(vec_w), .irq(irq)
    );

    gpio_pad_mux #(.W(W)) u_pad (
        .out_q(out_w), .dir_q(dir_w), .pen_q(pen_w), .drv_q(drv_w),
        .fsel_q(fsel_w), .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_up(pad_pull_up),
        .pad_pull_dn(pad_pull_dn), .pad_drive_full(pad_drive_full)
    );

    assign periph_in = sync_w;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int unsigned W     = 8,
    parameter int unsigned VEC_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [W-1:0]     pin_in,
    input logic [W-1:0]     sync_w,
    input logic [W-1:0]     pad_oe,
    input logic [W-1:0]     pad_pull_up,
    input logic [W-1:0]     pad_pull_dn,
    input logic [W-1:0]     pad_drive_full,
    input logic [VEC_W-1:0] vec_w,
    input logic             irq
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: two-stage latency from pad to synchronized level
    assert_sync_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (sync_w == $past(pin_in, 2)));

    // R3: the two pulls never fight and never coexist with an enabled driver
    assert_pull_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        ((pad_pull_up & pad_pull_dn) == '0) && (((pad_pull_up | pad_pull_dn) & pad_oe) == '0));

    // R4: reduced drive immediately after reset
    assert_drive_reset_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd0) |-> (pad_drive_full == '0));

    // R7: the request line agrees with the vector register
    assert_irq_vec_R7: assert property (@(posedge clk) disable iff (rst)
        irq == (vec_w != '0));

    // R8: vector values are even and in range
    assert_vec_range_R8: assert property (@(posedge clk) disable iff (rst)
        (vec_w[0] == 1'b0) && (vec_w <= VEC_W'(2 * W)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sync_w(sync_w),
    .pad_oe(pad_oe), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .pad_drive_full(pad_drive_full), .vec_w(vec_w), .irq(irq)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
    localparam int W     = 8;
    localparam int CLK_P = 10;

    logic clk = 0, rst = 1;
    logic bus_wr = 0, bus_rd = 0;
    logic [3:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [W-1:0] pin_in = 0, periph_out = 0, periph_oe = 0, periph_in;
    logic [W-1:0] pad_out, pad_oe, pad_pull_up, pad_pull_dn, pad_drive_full;
    logic irq;

    int checks = 0, errors = 0;

    logic [W-1:0] m_out = 0, m_dir = 0, m_pen = 0, m_drv = 0, m_fsel = 0;
    logic [W-1:0] m_ie = 0, m_edge = 0, m_flag = 0, m_pin = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_port_ctrl #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .periph_out(periph_out), .periph_oe(periph_oe),
        .periph_in(periph_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
        .pad_drive_full(pad_drive_full), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    function automatic logic [7:0] exp_vec(input logic [W-1:0] p);
        for (int i = 0; i < W; i++) if (p[i]) return 8'(2 * (i + 1));
        return 8'd0;
    endfunction

    function automatic logic [W-1:0] lowest(input logic [W-1:0] p);
        for (int i = 0; i < W; i++) if (p[i]) return W'(1) << i;
        return '0;
    endfunction

    task automatic set_pins(input logic [W-1:0] v);
        logic [W-1:0] rise, fall;
        @(negedge clk);
        pin_in = v;
        rise = v & ~m_pin;
        fall = ~v & m_pin;
        m_flag |= (m_edge & fall) | (~m_edge & rise);
        m_pin = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
        wr(a, d);
        case (a)
            1: m_out = d; 2: m_dir = d; 3: m_pen = d; 4: m_drv = d;
            5: m_fsel = d; 6: m_ie = d; 7: m_edge = d;
            8: m_flag &= ~d;
            default: ;
        endcase
    endtask

    task automatic check_pads();
        logic [W-1:0] eo, eoe, pon;
        #1;
        eo  = (m_fsel & periph_out) | (~m_fsel & m_out);
        eoe = m_dir & (~m_fsel | periph_oe);
        pon = m_pen & ~m_dir;
        chk(pad_oe == eoe, (m_fsel != 0) ? "R5 pad_oe" : "R2 pad_oe", pad_oe, eoe);
        chk((pad_out & eoe) == (eo & eoe), (m_fsel != 0) ? "R5 pad_out" : "R2 pad_out", pad_out, eo);
        chk(pad_pull_up == (pon & m_out), "R3 pull_up", pad_pull_up, pon & m_out);
        chk(pad_pull_dn == (pon & ~m_out), "R3 pull_dn", pad_pull_dn, pon & ~m_out);
        chk(pad_drive_full == m_drv, "R4 drive", pad_drive_full, m_drv);
        chk(periph_in == m_pin, "R5 periph_in", periph_in, m_pin);
        chk(irq == |(m_flag & m_ie), "R7 irq", irq, |(m_flag & m_ie));
    endtask

    task automatic check_irq_regs(input bit do_vec);
        logic [7:0] d;
        rd(8, d);
        chk(d == m_flag, "R6 flags", d, m_flag);
        if (do_vec) begin
            rd(9, d);
            chk(d == exp_vec(m_flag & m_ie), "R8 vector", d, exp_vec(m_flag & m_ie));
            m_flag &= ~lowest(m_flag & m_ie);   // R9 acknowledge
            rd(8, d);
            chk(d == m_flag, "R9 flags after vector read", d, m_flag);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R11 reset state
        for (int a = 1; a <= 9; a++) begin
            rd(4'(a), d);
            chk(d == 0, "R11 reset register", d, 0);
        end
        check_pads();
        chk(pad_oe == 0 && pad_pull_up == 0 && pad_pull_dn == 0, "R11 pads idle", pad_oe, 0);
        chk(pad_drive_full == 0, "R4 reduced drive at reset", pad_drive_full, 0);

        // R1 input register and ignored writes
        set_pins(8'hA5);
        rd(0, d);
        chk(d == 8'hA5, "R1 input register", d, 8'hA5);
        wr(0, 8'h3C);
        rd(0, d);
        chk(d == 8'hA5, "R1 write ignored", d, 8'hA5);
        check_pads();
        set_pins(8'h00);
        model_wr(8, 8'hFF);

        // R6 flag latches while masked, R7 no irq
        model_wr(7, 8'h00);
        set_pins(8'h48);
        check_pads();
        chk(irq == 0, "R7 masked no irq", irq, 0);
        check_irq_regs(1'b1);
        rd(9, d);
        chk(d == 0, "R8 empty vector", d, 0);

        // R8/R9 priority among lines 3 and 6
        model_wr(6, 8'h48);
        check_pads();
        check_irq_regs(1'b1);   // reports line 3 (8)
        check_irq_regs(1'b1);   // reports line 6 (14)
        check_irq_regs(1'b1);   // empty

        // R6 falling edge select and R10 write-1-to-clear
        model_wr(7, 8'h81);
        set_pins(8'h81);
        set_pins(8'h00);
        check_irq_regs(1'b0);
        model_wr(8, 8'h01);
        check_irq_regs(1'b0);
        model_wr(8, 8'hFF);
        check_pads();

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 4));
            case (op)
                0: model_wr(4'($urandom_range(1, 7)), 8'($urandom));
                1: set_pins(W'($urandom));
                2: begin
                    @(negedge clk);
                    periph_out = W'($urandom);
                    periph_oe  = W'($urandom);
                end
                3: check_irq_regs(1'b1);
                default: model_wr(8, 8'($urandom));
            endcase
            check_pads();
            if (op == 1) begin
                rd(0, d);
                chk(d == m_pin, "R1 input register random", d, m_pin);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule